// File: doc/BRIEF.md
# UART Receive Idle Timeout Detector

This block produces the receive-timeout interrupt of a UART receiver that stores incoming bytes in a FIFO. It counts bit periods during which no new byte arrives. Counting happens only while the FIFO holds at least one byte. When enough idle bit periods have passed, it raises a sticky raw status bit. Software can then collect a trailing partial burst without waiting for the FIFO fill level to trigger. It is also a cheap end-of-frame marker for protocols that separate messages by line silence.

The timeout length is 32 bit periods in normal mode and 64 bit periods when the high-speed select is set. The status is cleared in either of two ways: software reads the FIFO until it is empty, or software writes one to the status bit's clear strobe. A mask bit gates the raw status onto the interrupt line.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `toRaw` and `toInt` are both 0.
- R2: With `hiSpeed` = 0 and the FIFO not empty, `toRaw` rises on the clock edge that samples the 32nd `bitTick` after the idle count was last restarted. It stays 0 after 31 such ticks.
- R3: With `hiSpeed` = 1 and the FIFO not empty, `toRaw` rises on the edge that samples the 64th such `bitTick`. It stays 0 after 63.
- R4: While `fifoNotEmpty` = 0, the idle count is held at zero and `toRaw` cannot become set, however many `bitTick` pulses arrive.
- R5: A cycle with `byteRx` = 1 restarts the idle count from zero. A `bitTick` in the same cycle is not counted, and no expiry can occur in that cycle.
- R6: Once set, `toRaw` stays 1 through further ticks and received bytes until a clear condition occurs.
- R7: A cycle with `fifoRd` = 1 and `fifoNotEmpty` = 0 clears `toRaw` at the next edge. In that cycle, the FIFO status already reflects the read that drained it.
- R8: `toClrW1c` = 1 clears `toRaw` at the next edge and restarts the idle count. If an expiry lands in the same cycle, the clear wins.
- R9: After a write-one-to-clear with data still in the FIFO, `toRaw` sets again after another full timeout period of ticks.
- R10: `toInt` equals `toRaw` AND `intMask` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoNotEmpty | input | 1 | Receive FIFO holds at least one byte |
| byteRx | input | 1 | One-cycle strobe: a byte was written into the FIFO |
| bitTick | input | 1 | One-cycle strobe per received bit period |
| hiSpeed | input | 1 | 1 selects the 64-period timeout, 0 the 32-period timeout |
| fifoRd | input | 1 | One-cycle strobe: software read the FIFO |
| toClrW1c | input | 1 | Write-one-to-clear strobe for the timeout status |
| intMask | input | 1 | 1 lets the timeout status drive the interrupt |
| toRaw | output | 1 | Raw timeout status |
| toInt | output | 1 | Masked timeout interrupt |

## Verification
The bench checks exact-count boundaries: 31 versus 32 ticks and 63 versus 64 ticks. An off-by-one counter, or a mode select that is ignored, would fire one tick early or late. It runs long idle stretches with an empty FIFO, where a detector that does not require data would fire spuriously. It also times a clear strobe to coincide with an expiry: if the set wins, the status would remain high. Received-byte restarts and re-arming after a clear are tested as well. A design that did not reset the count on these events would fire too soon after them.

// File: rtl/rx_idle_timeout_pkg.sv
package rx_idle_timeout_pkg;

  // Strobes from the control half to the idle counter.
  typedef struct packed {
    logic cntClr;  // restart the idle count at zero
    logic cntInc;  // one idle bit period elapsed
  } idleStrobes_t;

endpackage

// File: rtl/rx_idle_cnt.sv
module rx_idle_cnt
  import rx_idle_timeout_pkg::*;
#(
  parameter int NORM_BITS = 32,
  parameter int FAST_BITS = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  idleStrobes_t strobes,
  input  logic         hiSpeed,
  output logic         atLimit
);
  localparam int CNT_W = $clog2(FAST_BITS + 1);
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_BITS - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_BITS - 1);

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = hiSpeed ? FAST_LAST : NORM_LAST;
  // >= so that a mode change during a count cannot skip past the limit
  assign atLimit = (idleCnt >= lastCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobes.cntClr) begin
      idleCnt <= '0;
    end else if (strobes.cntInc) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_idle_ctl.sv
module rx_idle_ctl
  import rx_idle_timeout_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fifoNotEmpty,
  input  logic         byteRx,
  input  logic         bitTick,
  input  logic         fifoRd,
  input  logic         toClrW1c,
  input  logic         atLimit,
  output idleStrobes_t strobes,
  output logic         toRaw
);
  logic expireNow;
  logic drainClr;

  // A received byte in the same cycle means the line is not idle.
  assign expireNow = bitTick && fifoNotEmpty && !byteRx && atLimit;
  assign drainClr  = fifoRd && !fifoNotEmpty;

  always_comb begin
    strobes.cntClr = byteRx || toClrW1c || !fifoNotEmpty || expireNow;
    strobes.cntInc = bitTick && fifoNotEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toRaw <= 1'b0;
    end else if (toClrW1c || drainClr) begin
      toRaw <= 1'b0;  // clear beats a same-cycle expiry
    end else if (expireNow) begin
      toRaw <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rx_idle_timeout_pkg::*;
#(
  parameter int NORM_BITS = 32,
  parameter int FAST_BITS = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic fifoNotEmpty,
  input  logic byteRx,
  input  logic bitTick,
  input  logic hiSpeed,
  input  logic fifoRd,
  input  logic toClrW1c,
  input  logic intMask,
  output logic toRaw,
  output logic toInt
);
  idleStrobes_t strobes;
  logic         atLimit;

  rx_idle_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .fifoNotEmpty (fifoNotEmpty),
    .byteRx       (byteRx),
    .bitTick      (bitTick),
    .fifoRd       (fifoRd),
    .toClrW1c     (toClrW1c),
    .atLimit      (atLimit),
    .strobes      (strobes),
    .toRaw        (toRaw)
  );

  rx_idle_cnt #(
    .NORM_BITS (NORM_BITS),
    .FAST_BITS (FAST_BITS)
  ) u_cnt (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .hiSpeed (hiSpeed),
    .atLimit (atLimit)
  );

  assign toInt = toRaw && intMask;
endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk (
  input logic clk,
  input logic rstN,
  input logic fifoNotEmpty,
  input logic byteRx,
  input logic bitTick,
  input logic fifoRd,
  input logic toClrW1c,
  input logic intMask,
  input logic toRaw,
  input logic toInt
);
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !intMask |-> !toInt);  // R10

  AST_EMPTY_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoNotEmpty && !toRaw) |=> !toRaw);  // R4

  AST_BYTE_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (byteRx && !toRaw) |=> !toRaw);  // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    toClrW1c |=> !toRaw);  // R8

  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRd && !fifoNotEmpty) |=> !toRaw);  // R7

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (toRaw && !toClrW1c && !(fifoRd && !fifoNotEmpty)) |=> toRaw);  // R6

  AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toRaw) |-> $past(bitTick));  // R2
endmodule

bind rx_idle_timeout rx_idle_timeout_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .fifoNotEmpty (fifoNotEmpty),
  .byteRx       (byteRx),
  .bitTick      (bitTick),
  .fifoRd       (fifoRd),
  .toClrW1c     (toClrW1c),
  .intMask      (intMask),
  .toRaw        (toRaw),
  .toInt        (toInt)
);

// File: tb/rx_idle_timeout_tb.sv
module rx_idle_timeout_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoNotEmpty = 1'b0;
  logic byteRx = 1'b0;
  logic bitTick = 1'b0;
  logic hiSpeed = 1'b0;
  logic fifoRd = 1'b0;
  logic toClrW1c = 1'b0;
  logic intMask = 1'b0;
  logic toRaw;
  logic toInt;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  int  mIdle = 0;
  bit  mRaw = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rx_idle_timeout u_dut (
    .clk(clk), .rstN(rstN), .fifoNotEmpty(fifoNotEmpty), .byteRx(byteRx),
    .bitTick(bitTick), .hiSpeed(hiSpeed), .fifoRd(fifoRd),
    .toClrW1c(toClrW1c), .intMask(intMask), .toRaw(toRaw), .toInt(toInt)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Reference model: idle time measured in ticks since the last restart.
  always @(posedge clk) begin
    int  lim;
    bit  expire;
    if (!rstN) begin
      mIdle = 0;
      mRaw  = 1'b0;
    end else begin
      lim = hiSpeed ? 64 : 32;
      expire = fifoNotEmpty && bitTick && !byteRx && (mIdle + 1 >= lim);
      if (toClrW1c || (fifoRd && !fifoNotEmpty)) mRaw = 1'b0;
      else if (expire) mRaw = 1'b1;
      if (byteRx || toClrW1c || !fifoNotEmpty || expire) mIdle = 0;
      else if (bitTick) mIdle = mIdle + 1;
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (rstN && !finished) begin
      chk("MODEL raw", toRaw, mRaw);
      chk("MODEL int", toInt, mRaw && intMask);
    end
    if (cycles > 100000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      report();
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      step();
      bitTick = 1'b0;
      step();
    end
  endtask

  task automatic pulseByte();
    byteRx = 1'b1;
    step();
    byteRx = 1'b0;
    step();
  endtask

  task automatic pulseW1c();
    toClrW1c = 1'b1;
    step();
    toClrW1c = 1'b0;
    step();
  endtask

  initial begin
    step();
    step();
    chk("R1 raw in reset", toRaw, 1'b0);
    rstN = 1'b1;
    step();
    chk("R1 raw after reset", toRaw, 1'b0);
    chk("R1 int after reset", toInt, 1'b0);

    // Empty FIFO: long idle never fires
    ticks(100);
    chk("R4 empty long idle", toRaw, 1'b0);

    // Normal mode boundary
    fifoNotEmpty = 1'b1;
    pulseByte();
    ticks(31);
    chk("R2 31 ticks", toRaw, 1'b0);
    ticks(1);
    chk("R2 32 ticks", toRaw, 1'b1);
    chk("R10 masked off", toInt, 1'b0);
    intMask = 1'b1;
    #1;
    chk("R10 masked on", toInt, 1'b1);

    // Sticky
    ticks(40);
    pulseByte();
    chk("R6 sticky", toRaw, 1'b1);

    // Write-one-to-clear, then refire
    pulseW1c();
    chk("R8 w1c clears", toRaw, 1'b0);
    chk("R10 follows clear", toInt, 1'b0);
    ticks(31);
    chk("R9 not yet refired", toRaw, 1'b0);
    ticks(1);
    chk("R9 refired", toRaw, 1'b1);

    // Drain clear
    fifoNotEmpty = 1'b0;
    fifoRd = 1'b1;
    step();
    fifoRd = 1'b0;
    step();
    chk("R7 drain clears", toRaw, 1'b0);
    ticks(80);
    chk("R4 empty after drain", toRaw, 1'b0);

    // Received bytes restart the count
    fifoNotEmpty = 1'b1;
    pulseByte();
    ticks(20);
    pulseByte();
    ticks(20);
    chk("R5 restart by byte", toRaw, 1'b0);
    bitTick = 1'b1;
    byteRx = 1'b1;
    step();
    bitTick = 1'b0;
    byteRx = 1'b0;
    step();
    ticks(31);
    chk("R5 tick with byte not counted", toRaw, 1'b0);
    ticks(1);
    chk("R5 fires after full period", toRaw, 1'b1);
    pulseW1c();

    // Clear coincident with expiry
    ticks(31);
    bitTick = 1'b1;
    toClrW1c = 1'b1;
    step();
    bitTick = 1'b0;
    toClrW1c = 1'b0;
    step();
    chk("R8 clear wins over expiry", toRaw, 1'b0);
    ticks(31);
    chk("R8 count restarted", toRaw, 1'b0);
    ticks(1);
    chk("R8 fires after restart", toRaw, 1'b1);
    pulseW1c();

    // High-speed mode boundary
    hiSpeed = 1'b1;
    pulseByte();
    ticks(63);
    chk("R3 63 ticks", toRaw, 1'b0);
    ticks(1);
    chk("R3 64 ticks", toRaw, 1'b1);
    intMask = 1'b0;
    #1;
    chk("R10 mask dropped", toInt, 1'b0);
    pulseW1c();
    ticks(40);
    chk("R3 hs no early fire", toRaw, 1'b0);

    step();
    report();
  end
endmodule